// File: doc/BRIEF.md
# Wake-up and Derivative Interrupt Controller

This block is the interrupt front end of a small 8-bit microcontroller. Eight active-low port pins act as level-sensitive request sources. They are enabled two at a time by four pair-enable bits. Any enabled pin that is held low is merged with a dedicated active-low external interrupt pin into a single external request path. That path has one pending flag, one vector and one global enable. A second, lower-priority source is driven by a timer event. It has its own flag, which only software clears and which software may also set to raise a software interrupt.

The controller decides which request, if any, is offered to the CPU. On acknowledge it records that a service routine is running, and a return strobe clears that record. The port and external path also drives an asynchronous wake signal while the core is in stop mode. No clock is needed for this wake signal, and the derivative source never drives it.

Top module: `wake_irq_ctrl`

## Requirements
- R1: After reset both flags are 0, no routine is in service, all pair enables are 0, and `irq_req_o` and `wake_o` are 0.
- R2: Pin levels pass through a two-flop synchronizer. A pin held low with its pair enabled sets `ext_flag_o`, which is visible after the third rising edge from the pin change.
- R3: A write with `ctl_we_i` stores `ctl_wdata_i[4+k]` as the enable for pins 2k and 2k+1 (k = 0..3). A low pin in a disabled pair, and bits 3:0 of the written value, have no effect on `ext_flag_o`.
- R4: `ext_pin_ni` held low sets the same `ext_flag_o`. An acknowledge of the external vector (`irq_sel_o` = 0) clears it on that edge. The flag sets again on the next edge if a source is still active.
- R5: The external request is offered (`irq_req_o` = 1, `irq_sel_o` = 0) only when `ext_flag_o`, `ext_gie_i` and no routine in service all hold.
- R6: The derivative request is offered (`irq_sel_o` = 1) only when `drv_flag_o`, `drv_gie_i` and `drv_local_en_i` are set, no routine is in service, and `ext_flag_o` is 0.
- R7: When both requests are eligible at once, the external one is offered.
- R8: `drv_flag_o` is set one edge after a `drv_hw_set_i` or `drv_sw_set_i` pulse. It is cleared only by `drv_sw_clr_i`, and a set wins over a clear in the same cycle. An acknowledge never clears it.
- R9: `ack_i` while `irq_req_o` is 1 sets `in_service_o` on that edge, and `ack_i` with no request has no effect. `reti_i` clears `in_service_o`, and it wins over an acknowledge in the same cycle. While a routine is in service, `irq_req_o` is 0.
- R10: `wake_o` is 1 combinationally when `stop_i` is 1 and either `ext_pin_ni` is low or a pin of an enabled pair is low. It is 0 outside stop mode and is never raised by `drv_flag_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_pin_ni | input | 8 | Port pin levels, low requests |
| ext_pin_ni | input | 1 | Dedicated external interrupt pin, low requests |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control write data, bits 7:4 are pair enables |
| ext_gie_i | input | 1 | Global enable of the external path |
| drv_gie_i | input | 1 | Global enable of the derivative interrupt |
| drv_local_en_i | input | 1 | Local enable of the derivative interrupt |
| drv_hw_set_i | input | 1 | Timer event pulse that sets the derivative flag |
| drv_sw_set_i | input | 1 | Software set of the derivative flag |
| drv_sw_clr_i | input | 1 | Software clear of the derivative flag |
| stop_i | input | 1 | Core is in stop mode |
| ack_i | input | 1 | CPU accepts the offered request |
| reti_i | input | 1 | Return from service routine |
| irq_req_o | output | 1 | Request offered to the CPU |
| irq_sel_o | output | 1 | Vector of offered request: 0 external, 1 derivative |
| ext_flag_o | output | 1 | External path pending flag |
| drv_flag_o | output | 1 | Derivative flag |
| in_service_o | output | 1 | A service routine is running |
| wake_o | output | 1 | Asynchronous stop-mode wake |

## Verification
Each of the eight pins is pulled low under each single-pair enable, with the unused control bits set. This separates a correct pair mapping from a shifted or swapped one. The external pin is held across an acknowledge to show the flag rearming while the request stays masked by in-service. The derivative flag is walked through all of its gating conditions, and then raised together with an external request. This shows both the blocking by a pending external flag and the priority. Wake is probed between clock edges with enabled and disabled pins, with the external pin, and with the derivative flag, both inside and outside stop mode.

// File: rtl/wake_irq_pkg.sv
package wake_irq_pkg;
  localparam int unsigned PINS      = 8;
  localparam int unsigned PAIRS     = PINS / 2;
  localparam int unsigned CTL_W     = 8;
  localparam int unsigned EN_LSB    = 4;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic {
    VEC_EXT = 1'b0,
    VEC_DRV = 1'b1
  } vec_e;
endpackage

// File: rtl/wake_irq_sync.sv
module wake_irq_sync #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/wake_irq_ext_path.sv
module wake_irq_ext_path #(
  parameter int unsigned PINS  = 8,
  parameter int unsigned PAIRS = PINS / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PINS-1:0]  pin_act_raw_i,
  input  logic [PINS-1:0]  pin_act_sync_i,
  input  logic             ext_act_raw_i,
  input  logic             ext_act_sync_i,
  input  logic [PAIRS-1:0] pair_en_i,
  input  logic             stop_i,
  input  logic             ack_ext_i,
  output logic             ext_flag_o,
  output logic             wake_o
);
  logic [PINS-1:0] pin_mask;
  logic            src_sync;
  logic            src_raw;
  logic            flag_q;

  for (genvar p = 0; p < PINS; p++) begin : g_mask
    assign pin_mask[p] = pair_en_i[p/2];
  end

  assign src_sync = ext_act_sync_i | (|(pin_act_sync_i & pin_mask));
  assign src_raw  = ext_act_raw_i  | (|(pin_act_raw_i  & pin_mask));

  // ack clear wins; a still-active level re-sets on the next edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (ack_ext_i) flag_q <= 1'b0;
    else if (src_sync)  flag_q <= 1'b1;
  end

  assign ext_flag_o = flag_q;
  assign wake_o     = stop_i & src_raw;

  a_r4_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_ext_i |=> !ext_flag_o);
  a_r2_level_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sync && !ack_ext_i) |=> ext_flag_o);
  a_r10_wake_in_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> stop_i);
endmodule

// File: rtl/wake_irq_drv_flag.sv
module wake_irq_drv_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_set_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  flag_q <= 1'b0;
    else if (hw_set_i | sw_set_i) flag_q <= 1'b1;
    else if (sw_clr_i)            flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_set_i || sw_set_i) |=> flag_o);
  a_r8_only_sw_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !sw_clr_i) |=> flag_o);
endmodule

// File: rtl/wake_irq_arb.sv
module wake_irq_arb
  import wake_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_flag_i,
  input  logic drv_flag_i,
  input  logic ext_gie_i,
  input  logic drv_gie_i,
  input  logic drv_local_en_i,
  input  logic ack_i,
  input  logic reti_i,
  output logic req_o,
  output vec_e sel_o,
  output logic in_svc_o,
  output logic ack_ext_o
);
  logic in_svc_q;
  logic ext_ok;
  logic drv_ok;

  assign ext_ok = ext_flag_i & ext_gie_i & ~in_svc_q;
  assign drv_ok = drv_flag_i & drv_gie_i & drv_local_en_i & ~in_svc_q & ~ext_flag_i;

  assign req_o     = ext_ok | drv_ok;
  assign sel_o     = ext_ok ? VEC_EXT : VEC_DRV;
  assign ack_ext_o = ack_i & ext_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             in_svc_q <= 1'b0;
    else if (reti_i)         in_svc_q <= 1'b0;
    else if (ack_i & req_o)  in_svc_q <= 1'b1;
  end

  assign in_svc_o = in_svc_q;

  a_r9_svc_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_svc_o |-> !req_o);
  a_r6_drv_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && sel_o == VEC_DRV) |-> (!ext_flag_i && drv_gie_i && drv_local_en_i));
  a_r9_reti_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i |=> !in_svc_o);
  a_r9_ack_enters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_o && !reti_i) |=> in_svc_o);
  a_r5_ext_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && sel_o == VEC_EXT) |-> (ext_gie_i && ext_flag_i));
endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl
  import wake_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PINS-1:0]  port_pin_ni,
  input  logic             ext_pin_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             ext_gie_i,
  input  logic             drv_gie_i,
  input  logic             drv_local_en_i,
  input  logic             drv_hw_set_i,
  input  logic             drv_sw_set_i,
  input  logic             drv_sw_clr_i,
  input  logic             stop_i,
  input  logic             ack_i,
  input  logic             reti_i,
  output logic             irq_req_o,
  output logic             irq_sel_o,
  output logic             ext_flag_o,
  output logic             drv_flag_o,
  output logic             in_service_o,
  output logic             wake_o
);
  logic [PAIRS-1:0] pair_en_q;
  logic [PINS:0]    act_raw;
  logic [PINS:0]    act_sync;
  logic             ack_ext;
  vec_e             sel;
  logic             unused_ctl_low;

  assign unused_ctl_low = ^ctl_wdata_i[EN_LSB-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pair_en_q <= '0;
    else if (ctl_we_i) pair_en_q <= ctl_wdata_i[EN_LSB +: PAIRS];
  end

  assign act_raw = {~ext_pin_ni, ~port_pin_ni};

  wake_irq_sync #(.W(PINS+1), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (act_raw),
    .q_o   (act_sync)
  );

  wake_irq_ext_path #(.PINS(PINS), .PAIRS(PAIRS)) u_ext (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pin_act_raw_i (act_raw[PINS-1:0]),
    .pin_act_sync_i(act_sync[PINS-1:0]),
    .ext_act_raw_i (act_raw[PINS]),
    .ext_act_sync_i(act_sync[PINS]),
    .pair_en_i     (pair_en_q),
    .stop_i        (stop_i),
    .ack_ext_i     (ack_ext),
    .ext_flag_o    (ext_flag_o),
    .wake_o        (wake_o)
  );

  wake_irq_drv_flag u_drv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hw_set_i(drv_hw_set_i),
    .sw_set_i(drv_sw_set_i),
    .sw_clr_i(drv_sw_clr_i),
    .flag_o  (drv_flag_o)
  );

  wake_irq_arb u_arb (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ext_flag_i    (ext_flag_o),
    .drv_flag_i    (drv_flag_o),
    .ext_gie_i     (ext_gie_i),
    .drv_gie_i     (drv_gie_i),
    .drv_local_en_i(drv_local_en_i),
    .ack_i         (ack_i),
    .reti_i        (reti_i),
    .req_o         (irq_req_o),
    .sel_o         (sel),
    .in_svc_o      (in_service_o),
    .ack_ext_o     (ack_ext)
  );

  assign irq_sel_o = sel;

  a_r8_ack_keeps_drv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_req_o && irq_sel_o && !drv_sw_clr_i) |=> drv_flag_o);
  a_r7_ext_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_flag_o && ext_gie_i && !in_service_o) |-> (irq_req_o && !irq_sel_o));
endmodule

// File: tb/wake_irq_ctrl_tb.sv
`timescale 1ns/1ps
module wake_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins_n = 8'hFF;
  logic       ext_n = 1'b1;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wd = 8'h00;
  logic       ext_gie = 1'b0, drv_gie = 1'b0, drv_len = 1'b0;
  logic       hw_set = 1'b0, sw_set = 1'b0, sw_clr = 1'b0;
  logic       stop = 1'b0, ack = 1'b0, reti = 1'b0;
  logic       req, sel, eflag, dflag, insvc, wake;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  wake_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .port_pin_ni(pins_n), .ext_pin_ni(ext_n),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd), .ext_gie_i(ext_gie),
    .drv_gie_i(drv_gie), .drv_local_en_i(drv_len), .drv_hw_set_i(hw_set),
    .drv_sw_set_i(sw_set), .drv_sw_clr_i(sw_clr), .stop_i(stop),
    .ack_i(ack), .reti_i(reti), .irq_req_o(req), .irq_sel_o(sel),
    .ext_flag_o(eflag), .drv_flag_o(dflag), .in_service_o(insvc), .wake_o(wake)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1; cyc(1); reti = 1'b0;
  endtask

  task automatic write_ctl(input logic [7:0] v);
    ctl_wd = v; ctl_we = 1'b1; cyc(1); ctl_we = 1'b0;
  endtask

  // sources must already be inactive and synced
  task automatic clear_ext();
    ext_gie = 1'b1; #0;
    pulse_ack(); pulse_reti();
    ext_gie = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ext_flag", eflag, 0);
    check("R1 drv_flag", dflag, 0);
    check("R1 in_service", insvc, 0);
    check("R1 irq_req", req, 0);
    check("R1 wake", wake, 0);
    pins_n = 8'h00; cyc(3);
    check("R1 pair enables off", eflag, 0);
    pins_n = 8'hFF; cyc(3);
  endtask

  task automatic t_pairs();
    for (int k = 0; k < 4; k++) begin
      write_ctl(8'h0F | (8'h10 << k));
      for (int i = 0; i < 8; i++) begin
        pins_n = ~(8'h01 << i);
        cyc(2);
        check($sformatf("R2 sync delay pin%0d", i), eflag, 0);
        cyc(1);
        check($sformatf("R3 pair%0d pin%0d", k, i), eflag, (i/2 == k) ? 1 : 0);
        pins_n = 8'hFF; cyc(3);
        if (i/2 == k) clear_ext();
      end
    end
    write_ctl(8'h00);
  endtask

  task automatic t_ext_pin();
    ext_n = 1'b0; cyc(3);
    check("R4 ext pin sets flag", eflag, 1);
    check("R5 no req without gie", req, 0);
    ext_gie = 1'b1; #1;
    check("R5 req with gie", req, 1);
    check("R5 ext vector", sel, 0);
    cyc(1);
    pulse_ack();
    check("R4 ack clears flag", eflag, 0);
    check("R9 in service", insvc, 1);
    cyc(1);
    check("R4 level re-sets flag", eflag, 1);
    check("R9 masked in service", req, 0);
    ext_n = 1'b1; cyc(3);
    pulse_reti();
    check("R9 reti clears", insvc, 0);
    check("R5 req after reti", req, 1);
    pulse_ack(); pulse_reti();
    check("R4 flag cleared", eflag, 0);
    ext_gie = 1'b0;
  endtask

  task automatic t_drv();
    hw_set = 1'b1; cyc(1); hw_set = 1'b0;
    check("R8 hw set", dflag, 1);
    check("R6 no req gie off", req, 0);
    drv_gie = 1'b1; #1;
    check("R6 no req local off", req, 0);
    drv_len = 1'b1; #1;
    check("R6 req", req, 1);
    check("R6 drv vector", sel, 1);
    cyc(1);
    pulse_ack();
    check("R8 ack keeps flag", dflag, 1);
    check("R9 in service drv", insvc, 1);
    check("R9 masked drv", req, 0);
    pulse_reti();
    check("R6 req again", req, 1);
    sw_clr = 1'b1; cyc(1); sw_clr = 1'b0;
    check("R8 sw clear", dflag, 0);
    check("R6 no req flag off", req, 0);
    sw_set = 1'b1; cyc(1); sw_set = 1'b0;
    check("R8 sw set", dflag, 1);
    sw_set = 1'b1; sw_clr = 1'b1; cyc(1); sw_set = 1'b0; sw_clr = 1'b0;
    check("R8 set wins", dflag, 1);
    hw_set = 1'b1; sw_clr = 1'b1; cyc(1); hw_set = 1'b0; sw_clr = 1'b0;
    check("R8 hw set wins", dflag, 1);
  endtask

  task automatic t_priority();
    // drv flag still set and enabled
    ext_n = 1'b0; cyc(3);
    ext_n = 1'b1; cyc(4);
    check("R6 blocked by ext pending", req, 0);
    ext_gie = 1'b1; #1;
    check("R7 ext wins req", req, 1);
    check("R7 ext wins sel", sel, 0);
    cyc(1);
    pulse_ack(); pulse_reti();
    check("R7 ext flag cleared", eflag, 0);
    check("R7 drv after ext", sel, 1);
    check("R7 drv req", req, 1);
    ext_gie = 1'b0;
  endtask

  task automatic t_ack_noreq();
    drv_gie = 1'b0; #1;
    check("R9 no req", req, 0);
    pulse_ack();
    check("R9 ack without req", insvc, 0);
    sw_clr = 1'b1; cyc(1); sw_clr = 1'b0;
    drv_len = 1'b0;
  endtask

  task automatic t_wake();
    write_ctl(8'h80);
    pins_n = 8'h7F; #1;
    check("R10 no wake outside stop", wake, 0);
    stop = 1'b1; #1;
    check("R10 wake enabled pin", wake, 1);
    pins_n = 8'hFE; #1;
    check("R10 disabled pin no wake", wake, 0);
    pins_n = 8'hFF; ext_n = 1'b0; #1;
    check("R10 wake ext pin", wake, 1);
    ext_n = 1'b1;
    sw_set = 1'b1; cyc(1); sw_set = 1'b0; #1;
    check("R10 drv no wake", wake, 0);
    sw_clr = 1'b1; cyc(1); sw_clr = 1'b0;
    stop = 1'b0; cyc(4);
    clear_ext();
  endtask

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    t_reset();
    t_pairs();
    t_ext_pin();
    t_drv();
    t_priority();
    t_ack_noreq();
    t_wake();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); end
    join_any
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=0 expected=1");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule